// File: doc/BRIEF.md
# SCL Clock Period Generator

This block produces the serial clock of a two-wire bus master. It gives a drive-low request for an open-drain SCL pad and decides when to pull the line low and when to let it go. It holds two pairs of period counts, one for standard speed and one for fast speed. A speed code picks the pair. The low phase is timed from the cycle in which the block starts pulling the line low. The high phase is timed only while the line is actually sensed high. A slave that holds SCL low therefore lengthens the high phase by exactly the cycles it holds the line. The high phase also carries a fixed overhead of 8 cycles on top of the programmed count.

The counts and the speed code are captured only while the block is disabled. While enabled it runs from the captured copy. On each SCL edge that it creates, it raises a one-cycle marker for the neighbouring data shifter. START/STOP sequencing and data shifting are not part of this block.

Top module: `scl_period_gen`

## Requirements
- R1: During and right after reset, `scl_pull_low`, `edge_fall` and `edge_rise` are 0.
- R2: A captured speed code of 2 (binary 10) selects the fast count pair. Every other code (1 nominally, also 0 and 3) selects the standard pair.
- R3: A low phase lasts the selected low count plus 1 clock cycles, counted from the first cycle in which `scl_pull_low` is 1.
- R4: A high phase lasts the selected high count plus 8 clock cycles in which `scl_sense` is 1. Each such cycle is counted at the rising clock edge.
- R5: Counts and speed code are captured on each clock edge at which `enable` is 0. Changing them while `enable` is 1 has no effect on the generated periods.
- R6: During a high phase, a clock edge at which `scl_sense` is 0 is not counted, so each stretched cycle adds one cycle to the high phase.
- R7: One cycle after `enable` is 0 at a clock edge, `scl_pull_low` is 0 and both period counts restart. After enable, the first phase is a full high phase.
- R8: `edge_fall` is 1 for exactly the first cycle of each low phase. `edge_rise` is 1 for exactly the first cycle of the high phase that follows a completed low phase. Disabling produces neither marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the generator; 0 captures the settings |
| speed_code | input | 2 | 2 = fast pair, otherwise standard pair |
| std_high_cnt | input | CNT_W | Standard-speed high count |
| std_low_cnt | input | CNT_W | Standard-speed low count |
| fast_high_cnt | input | CNT_W | Fast-speed high count |
| fast_low_cnt | input | CNT_W | Fast-speed low count |
| scl_sense | input | 1 | Sensed level of the SCL line |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| edge_fall | output | 1 | One-cycle marker at the start of a low phase |
| edge_rise | output | 1 | One-cycle marker at the start of a high phase |

## Verification
The assertions check on every cycle that:
- the line is released one cycle after a disable;
- the two edge markers never coincide, and each matches a real transition of the drive;
- a released line that is sensed low stays released;
- the captured settings do not move while the block runs;
- the low count never passes its limit.

The exact phase lengths can only be shown by the bench scenarios, compared against a behavioural model on every clock. These include the 8-cycle high overhead, the extra cycle in the low phase, the choice between the pairs, the count changes that are ignored while running, and the length added by a stretching slave.

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int CNT_W  = 16,
  parameter int HI_OVH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       speed_code,
  input  logic [CNT_W-1:0] std_high_cnt,
  input  logic [CNT_W-1:0] std_low_cnt,
  input  logic [CNT_W-1:0] fast_high_cnt,
  input  logic [CNT_W-1:0] fast_low_cnt,
  input  logic             scl_sense,
  output logic             scl_pull_low,
  output logic             edge_fall,
  output logic             edge_rise
);
  localparam logic [1:0]   SPD_FAST = 2'd2;
  localparam logic [CNT_W:0] OVH_M1 = (CNT_W+1)'(HI_OVH - 1);

  logic [1:0]       spd_q;
  logic [CNT_W-1:0] s_hi_q, s_lo_q, f_hi_q, f_lo_q;
  logic [CNT_W:0]   cnt;
  logic             low_q, fall_q, rise_q;

  wire             fast    = (spd_q == SPD_FAST);
  wire [CNT_W:0]   hi_last = {1'b0, fast ? f_hi_q : s_hi_q} + OVH_M1;
  wire [CNT_W:0]   lo_last = {1'b0, fast ? f_lo_q : s_lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd_q  <= '0;
      s_hi_q <= '0;
      s_lo_q <= '0;
      f_hi_q <= '0;
      f_lo_q <= '0;
      cnt    <= '0;
      low_q  <= 1'b0;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      rise_q <= 1'b0;
      if (!enable) begin
        spd_q  <= speed_code;
        s_hi_q <= std_high_cnt;
        s_lo_q <= std_low_cnt;
        f_hi_q <= fast_high_cnt;
        f_lo_q <= fast_low_cnt;
        cnt    <= '0;
        low_q  <= 1'b0;
      end else if (!low_q) begin
        if (scl_sense) begin
          if (cnt == hi_last) begin
            cnt    <= '0;
            low_q  <= 1'b1;
            fall_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end else begin
        if (cnt == lo_last) begin
          cnt    <= '0;
          low_q  <= 1'b0;
          rise_q <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign scl_pull_low = low_q;
  assign edge_fall    = fall_q;
  assign edge_rise    = rise_q;

  p_release_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_pull_low);
  p_edges_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(edge_fall && edge_rise));
  p_fall_real_r8: assert property (@(posedge clk) disable iff (!rst_n)
    edge_fall |-> (scl_pull_low && !$past(scl_pull_low)));
  p_rise_real_r8: assert property (@(posedge clk) disable iff (!rst_n)
    edge_rise |-> (!scl_pull_low && $past(scl_pull_low)));
  p_stretch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull_low && !scl_sense) |=> !scl_pull_low);
  p_frozen_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> ($stable(spd_q) && $stable(s_hi_q) && $stable(s_lo_q)
                                   && $stable(f_hi_q) && $stable(f_lo_q)));
  p_low_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_low |-> (cnt <= lo_last));
endmodule

// File: tb/sim_scl_period_gen.sv
module sim_scl_period_gen;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, stretch = 1'b0;
  logic [1:0] speed_code = 2'd1;
  logic [W-1:0] s_hi = '0, s_lo = '0, f_hi = '0, f_lo = '0;
  logic scl_pull_low, edge_fall, edge_rise;
  wire scl_sense = !(scl_pull_low || stretch);
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  scl_period_gen #(.CNT_W(W), .HI_OVH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .speed_code(speed_code),
    .std_high_cnt(s_hi), .std_low_cnt(s_lo), .fast_high_cnt(f_hi), .fast_low_cnt(f_lo),
    .scl_sense(scl_sense), .scl_pull_low(scl_pull_low),
    .edge_fall(edge_fall), .edge_rise(edge_rise));

  // behavioural reference
  bit m_low, m_fp, m_rp;
  int m_el, c_hi, c_lo, c_sp;
  int sh_hi, sh_lo, fh_hi, fh_lo;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_low = 0; m_el = 0; m_fp = 0; m_rp = 0;
      c_sp = 0; sh_hi = 0; sh_lo = 0; fh_hi = 0; fh_lo = 0;
    end else begin
      bit line_up;
      line_up = !(m_low || stretch);
      m_fp = 0; m_rp = 0;
      if (!enable) begin
        c_sp = speed_code; sh_hi = s_hi; sh_lo = s_lo; fh_hi = f_hi; fh_lo = f_lo;
        m_low = 0; m_el = 0;
      end else begin
        c_hi = (c_sp == 2) ? fh_hi : sh_hi;
        c_lo = (c_sp == 2) ? fh_lo : sh_lo;
        if (!m_low) begin
          if (line_up) begin
            m_el++;
            if (m_el == c_hi + 8) begin m_low = 1; m_el = 0; m_fp = 1; end
          end
        end else begin
          m_el++;
          if (m_el == c_lo + 1) begin m_low = 0; m_el = 0; m_rp = 1; end
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R3 R4 R8 per-cycle drive", scl_pull_low, m_low);
    check("R8 per-cycle fall marker", edge_fall, m_fp);
    check("R8 per-cycle rise marker", edge_rise, m_rp);
  end

  task automatic run_low(output int n);
    n = 0;
    do @(negedge clk); while (!edge_fall);
    while (scl_pull_low) begin n++; @(negedge clk); end
  endtask

  task automatic run_high(output int n);
    n = 0;
    while (!scl_pull_low) begin n++; @(negedge clk); end
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset drive", scl_pull_low, 0);
    check("R1 reset fall", edge_fall, 0);
    check("R1 reset rise", edge_rise, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset drive", scl_pull_low, 0);
    s_hi = 5; s_lo = 7; f_hi = 2; f_lo = 3; speed_code = 2'd1;
    @(negedge clk);
    enable = 1'b1;
    run_high(n); check("R4 R7 first high std", n, 13);
    n = 0;
    while (scl_pull_low) begin n++; @(negedge clk); end
    check("R3 low std", n, 8);
    check("R8 rise marker", edge_rise, 1);
    run_high(n); check("R4 high std", n, 13);
    check("R8 fall marker", edge_fall, 1);
    // R5: change settings while running
    s_lo = 20; speed_code = 2'd2;
    run_low(n); check("R5 low unchanged", n, 8);
    run_high(n); check("R5 high unchanged", n, 13);
    // R7: disable mid low phase
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R7 released", scl_pull_low, 0);
    check("R7 no rise marker", edge_rise, 0);
    @(negedge clk);
    enable = 1'b1;
    run_high(n); check("R2 R7 first high fast", n, 10);
    run_low(n); check("R2 low fast", n, 4);
    run_high(n); check("R2 high fast", n, 10);
    enable = 1'b0; speed_code = 2'd3;
    @(negedge clk);
    enable = 1'b1;
    run_high(n); check("R2 code3 high std", n, 13);
    run_low(n); check("R2 code3 low std", n, 21);
    // R6: stretch at the start of the high phase
    stretch = 1'b1;
    n = 0;
    repeat (6) begin n++; @(negedge clk); end
    stretch = 1'b0;
    while (!scl_pull_low) begin n++; @(negedge clk); end
    check("R6 stretched high", n, 19);
    run_low(n); check("R3 low after stretch", n, 21);
    run_high(n); check("R4 high after stretch", n, 13);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 idle released", scl_pull_low, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule